// File: doc/BRIEF.md
# Mode-Steered Address and General-Purpose Pin Port

This block controls four pins of a microcontroller. Its small register set sits on an 8-bit peripheral bus. The chip operating mode decides what each pin does. A pin either carries one bit of the external address, taken from the bus controller, or works as a general-purpose pin. As a general-purpose pin it drives a data-register bit or reads an input level. Software sets the pin directions through a direction register that cannot be read back. Software also sets a pull-up enable and an open-drain enable for each pin. A readback register returns the level of every pin.

A small standby state machine follows the two standby inputs. It has four states:

- `ST_RUN`: normal operation.
- `ST_SW_HOLD`: software standby, with the address pins held at the value captured on entry.
- `ST_SW_HIZ`: software standby, with the address pins released.
- `ST_HW_OFF`: hardware standby, with every pin released and pull-ups off.

The transitions are:

- RUN→HW_OFF when `hw_stby` is high.
- RUN→SW_HOLD when `sw_stby` is high and `stby_oe` is 1.
- RUN→SW_HIZ when `sw_stby` is high and `stby_oe` is 0.
- SW_HOLD or SW_HIZ→HW_OFF when `hw_stby` is high.
- SW_HOLD or SW_HIZ→RUN when `sw_stby` falls.
- HW_OFF→RUN when `hw_stby` is low.

Hardware standby wins over software standby. Every transition happens at the clock edge that samples its condition.

Top module: `addr_gpio_port`

## Requirements
- R1: The register addresses are: data 0xFF69, pull-up 0xFF70, open-drain 0xFF77, readback 0xFF59 and direction 0xFEB9. A write with `reg_wr` high stores bits 3:0 at the clock edge. With `reg_rd` high, data, pull-up and open-drain read as {4'hF, contents}. With `reg_rd` low, `reg_rdata` is 0x00. Data, pull-up and open-drain reset to 0.
- R2: A read of the direction address always returns 0xFF, whatever the direction register holds.
- R3: The direction register is 0 after reset. At each clock edge where `hw_stby` is high, it clears to 0, and every register write is ignored. In `ST_HW_OFF`, `pin_oe`, `pin_pu` and `pin_od` are all 0.
- R4: The direction register keeps its contents through software standby.
- R5: In RUN with `mode` equal to 4 or 5, every pin is an output driving `addr_src`. The direction bits have no effect.
- R6: In RUN with `mode` equal to 6, a pin whose direction bit is 1 drives its `addr_src` bit. A pin whose direction bit is 0 is an input.
- R7: In `ST_SW_HOLD`, address pins keep driving the `addr_src` value sampled at the entry edge, even if `addr_src` later changes.
- R8: In `ST_SW_HIZ`, address pins are undriven. General-purpose output pins keep driving their data bits.
- R9: In every other mode (0-3 and 7), a direction bit of 1 drives the data bit on that pin, and a direction bit of 0 makes the pin an input.
- R10: Readback returns {4'hF, per-pin value}. For a driving pin the value is the driven value. For any other pin it is `pin_in` seen through a two-flop synchronizer, so a change shows after the second clock edge. Writes to the readback address have no effect.
- R11: `pin_pu` follows the pull-up bit only for pins that are not driving, and only outside hardware standby.
- R12: On a driving pin whose open-drain bit is 1, a value of 1 gives `pin_oe`=0 and a value of 0 gives `pin_oe`=1. `pin_od` is the open-drain bit ANDed with the driving state. `pin_out` is the driven value for driving pins and 0 elsewhere.
- R13: A read of any other address returns 0xFF. A write to another address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 16 | Register bus address (low 16 bits) |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data (combinational) |
| addr_src | input | 4 | Address bits from the bus controller |
| mode | input | 3 | Chip operating mode |
| hw_stby | input | 1 | Hardware standby request |
| sw_stby | input | 1 | Software standby request |
| stby_oe | input | 1 | 1: hold address outputs in software standby; 0: release them |
| pin_in | input | 4 | Pin input levels (asynchronous) |
| pin_out | output | 4 | Per-pin output value |
| pin_oe | output | 4 | Per-pin output enable |
| pin_pu | output | 4 | Per-pin pull-up enable |
| pin_od | output | 4 | Per-pin open-drain enable |

## Verification
A wrong direction bit or a wrong mode decode shows up on `pin_oe` and `pin_out` in the same cycle as the register write that caused it. The exhaustive mode-by-direction sweep catches it at once. A standby state machine stuck in or out of a state shows up one edge after the standby input changes. The symptom is an address that follows `addr_src`, pins that stay driven, or pull-ups that stay on. A broken synchronizer depth shows up as readback changing one edge too early or too late.

// File: rtl/agp_pkg.sv
package agp_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SW_HOLD = 2'd1,
        ST_SW_HIZ  = 2'd2,
        ST_HW_OFF  = 2'd3
    } stby_state_e;

    localparam logic [15:0] DEF_ADDR_DIR  = 16'hFEB9;
    localparam logic [15:0] DEF_ADDR_PINS = 16'hFF59;
    localparam logic [15:0] DEF_ADDR_DATA = 16'hFF69;
    localparam logic [15:0] DEF_ADDR_PULL = 16'hFF70;
    localparam logic [15:0] DEF_ADDR_OPEN = 16'hFF77;

    localparam logic [2:0] MODE_ADDR_A = 3'd4;
    localparam logic [2:0] MODE_ADDR_B = 3'd5;
    localparam logic [2:0] MODE_ADDR_SEL = 3'd6;

endpackage

// File: rtl/agp_sync.sv
module agp_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/agp_regs.sv
module agp_regs
    import agp_pkg::*;
#(
    parameter int          W         = 4,
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] ADDR_DIR  = DEF_ADDR_DIR,
    parameter logic [15:0] ADDR_PINS = DEF_ADDR_PINS,
    parameter logic [15:0] ADDR_DATA = DEF_ADDR_DATA,
    parameter logic [15:0] ADDR_PULL = DEF_ADDR_PULL,
    parameter logic [15:0] ADDR_OPEN = DEF_ADDR_OPEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [W-1:0]      pin_level,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      data_q,
    output logic [W-1:0]      pull_q,
    output logic [W-1:0]      open_q
);
    logic          wr_ok;
    logic [W-1:0]  wr_bits;
    logic          unused_hi;

    assign wr_ok     = reg_wr && !hw_stby;
    assign wr_bits   = reg_wdata[W-1:0];
    assign unused_hi = ^reg_wdata[DATA_W-1:W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (hw_stby) begin
            dir_q <= '0;
        end else if (wr_ok && reg_addr == ADDR_DIR[ADDR_W-1:0]) begin
            dir_q <= wr_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            pull_q <= '0;
            open_q <= '0;
        end else if (wr_ok) begin
            if (reg_addr == ADDR_DATA[ADDR_W-1:0]) data_q <= wr_bits;
            if (reg_addr == ADDR_PULL[ADDR_W-1:0]) pull_q <= wr_bits;
            if (reg_addr == ADDR_OPEN[ADDR_W-1:0]) open_q <= wr_bits;
        end
    end

    always_comb begin
        reg_rdata = '1;
        if (!reg_rd) begin
            reg_rdata = '0;
        end else if (reg_addr == ADDR_DATA[ADDR_W-1:0]) begin
            reg_rdata[W-1:0] = data_q;
        end else if (reg_addr == ADDR_PULL[ADDR_W-1:0]) begin
            reg_rdata[W-1:0] = pull_q;
        end else if (reg_addr == ADDR_OPEN[ADDR_W-1:0]) begin
            reg_rdata[W-1:0] = open_q;
        end else if (reg_addr == ADDR_PINS[ADDR_W-1:0]) begin
            reg_rdata[W-1:0] = pin_level;
        end
    end

    p_dir_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (dir_q == '0));

    p_dir_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby && !(reg_wr && reg_addr == ADDR_DIR[ADDR_W-1:0]))
        |=> $stable(dir_q));

endmodule

// File: rtl/agp_stby_fsm.sv
module agp_stby_fsm
    import agp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hw_stby,
    input  logic         sw_stby,
    input  logic         stby_oe,
    input  logic [W-1:0] addr_src,
    output stby_state_e  state,
    output logic [W-1:0] held_addr
);
    stby_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (hw_stby)      state_nx = ST_HW_OFF;
                else if (sw_stby) state_nx = stby_oe ? ST_SW_HOLD : ST_SW_HIZ;
            end
            ST_SW_HOLD, ST_SW_HIZ: begin
                if (hw_stby)       state_nx = ST_HW_OFF;
                else if (!sw_stby) state_nx = ST_RUN;
            end
            ST_HW_OFF: begin
                if (!hw_stby) state_nx = ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               held_addr <= '0;
        else if (state == ST_RUN) held_addr <= addr_src;
    end

    p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SW_HOLD) |=> $stable(held_addr));

    p_hw_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (state == ST_HW_OFF));

endmodule

// File: rtl/agp_pin_mux.sv
module agp_pin_mux
    import agp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   mode,
    input  stby_state_e  state,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] pull_q,
    input  logic [W-1:0] open_q,
    input  logic [W-1:0] addr_live,
    input  logic [W-1:0] addr_held,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_pu,
    output logic [W-1:0] pin_od,
    output logic [W-1:0] pin_level
);
    logic         all_addr;
    logic         sel_addr;
    logic [W-1:0] addr_fn;
    logic [W-1:0] drive;
    logic [W-1:0] value;
    logic         awake;

    assign all_addr = (mode == MODE_ADDR_A) || (mode == MODE_ADDR_B);
    assign sel_addr = (mode == MODE_ADDR_SEL);
    assign awake    = (state != ST_HW_OFF);

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            assign addr_fn[i] = all_addr || (sel_addr && dir_q[i]);

            always_comb begin
                drive[i] = 1'b0;
                value[i] = 1'b0;
                unique case (state)
                    ST_RUN: begin
                        drive[i] = addr_fn[i] || dir_q[i];
                        value[i] = addr_fn[i] ? addr_live[i] : data_q[i];
                    end
                    ST_SW_HOLD: begin
                        drive[i] = addr_fn[i] || dir_q[i];
                        value[i] = addr_fn[i] ? addr_held[i] : data_q[i];
                    end
                    ST_SW_HIZ: begin
                        drive[i] = !addr_fn[i] && dir_q[i];
                        value[i] = data_q[i];
                    end
                    ST_HW_OFF: begin
                        drive[i] = 1'b0;
                        value[i] = 1'b0;
                    end
                    default: begin
                        drive[i] = 1'b0;
                        value[i] = 1'b0;
                    end
                endcase
            end

            assign pin_out[i]   = drive[i] && value[i];
            assign pin_oe[i]    = drive[i] && !(open_q[i] && value[i]);
            assign pin_od[i]    = drive[i] && open_q[i];
            assign pin_pu[i]    = awake && !drive[i] && pull_q[i];
            assign pin_level[i] = drive[i] ? value[i] : pin_sync[i];
        end
    endgenerate

    p_od_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & pin_od) & pin_oe) == '0);

endmodule

// File: rtl/addr_gpio_port.sv
module addr_gpio_port
    import agp_pkg::*;
#(
    parameter int          W          = 4,
    parameter int          DATA_W     = 8,
    parameter int          ADDR_W     = 16,
    parameter int          SYNC_DEPTH = 2,
    parameter logic [15:0] ADDR_DIR   = DEF_ADDR_DIR,
    parameter logic [15:0] ADDR_PINS  = DEF_ADDR_PINS,
    parameter logic [15:0] ADDR_DATA  = DEF_ADDR_DATA,
    parameter logic [15:0] ADDR_PULL  = DEF_ADDR_PULL,
    parameter logic [15:0] ADDR_OPEN  = DEF_ADDR_OPEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [W-1:0]      addr_src,
    input  logic [2:0]        mode,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              stby_oe,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_pu,
    output logic [W-1:0]      pin_od
);
    logic [W-1:0] dir_q, data_q, pull_q, open_q;
    logic [W-1:0] pin_sync, pin_level, held_addr;
    stby_state_e  state;

    agp_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    agp_regs #(
        .W(W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .ADDR_DIR(ADDR_DIR), .ADDR_PINS(ADDR_PINS), .ADDR_DATA(ADDR_DATA),
        .ADDR_PULL(ADDR_PULL), .ADDR_OPEN(ADDR_OPEN)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .pin_level(pin_level),
        .dir_q(dir_q), .data_q(data_q), .pull_q(pull_q), .open_q(open_q)
    );

    agp_stby_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .stby_oe(stby_oe), .addr_src(addr_src), .state(state),
        .held_addr(held_addr)
    );

    agp_pin_mux #(.W(W)) u_mux (
        .clk(clk), .rst_n(rst_n), .mode(mode), .state(state),
        .dir_q(dir_q), .data_q(data_q), .pull_q(pull_q), .open_q(open_q),
        .addr_live(addr_src), .addr_held(held_addr), .pin_sync(pin_sync),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_od(pin_od),
        .pin_level(pin_level)
    );

    p_hw_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HW_OFF) |-> (pin_oe == '0 && pin_pu == '0 && pin_od == '0));

    p_mode45_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && (mode == MODE_ADDR_A || mode == MODE_ADDR_B))
        |-> (pin_out == addr_src));

    p_pull_input_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

endmodule

// File: tb/addr_gpio_port_tb_top.sv
`timescale 1ns/1ps
module addr_gpio_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic [3:0]  addr_src = '0;
    logic [2:0]  mode = '0;
    logic        hw_stby = 1'b0;
    logic        sw_stby = 1'b0;
    logic        stby_oe = 1'b0;
    logic [3:0]  pin_in = 4'hA;
    logic [3:0]  pin_out, pin_oe, pin_pu, pin_od;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [15:0] A_DIR  = 16'hFEB9;
    localparam logic [15:0] A_PINS = 16'hFF59;
    localparam logic [15:0] A_DATA = 16'hFF69;
    localparam logic [15:0] A_PULL = 16'hFF70;
    localparam logic [15:0] A_OPEN = 16'hFF77;

    always #2 clk = ~clk;

    addr_gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .addr_src(addr_src), .mode(mode), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .stby_oe(stby_oe), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pu(pin_pu), .pin_od(pin_od)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [15:0] a, input logic [7:0] exp);
        reg_addr = a; reg_rd = 1'b1;
        #0.5;
        check(req, reg_rdata, exp);
        reg_rd = 1'b0;
    endtask

    function automatic logic [3:0] amask(input logic [2:0] m, input logic [3:0] d);
        if (m == 3'd4 || m == 3'd5) return 4'hF;
        if (m == 3'd6) return d;
        return 4'h0;
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 reset state
        rd_check("R1 data reset", A_DATA, 8'hF0);
        rd_check("R1 pull reset", A_PULL, 8'hF0);
        rd_check("R1 open reset", A_OPEN, 8'hF0);
        check("R3 oe after reset", {4'h0, pin_oe}, 8'h00);
        reg_addr = A_DATA;
        #0.5 check("R1 rdata without rd", reg_rdata, 8'h00);

        // R2 direction reads as all ones
        wr(A_DIR, 8'h05);
        rd_check("R2 dir read", A_DIR, 8'hFF);
        check("R9 dir took effect", {4'h0, pin_oe}, 8'h05);
        wr(A_DIR, 8'h00);

        // R13 unmapped
        wr(A_DATA, 8'h03);
        wr(16'h1234, 8'h0C);
        rd_check("R13 unmapped read", 16'h1234, 8'hFF);
        rd_check("R13 data unchanged", A_DATA, 8'hF3);

        // R5 R6 R9 R10 R11 sweep of mode x direction
        wr(A_PULL, 8'h0F);
        wr(A_OPEN, 8'h00);
        for (int m = 0; m < 8; m++) begin
            for (int d = 0; d < 16; d++) begin
                logic [3:0] am, dv, drv, val, rb;
                mode = 3'(m);
                addr_src = ~4'(d);
                wr(A_DIR, 8'(d));
                wr(A_DATA, 8'(d ^ 5));
                am  = amask(3'(m), 4'(d));
                dv  = 4'(d ^ 5);
                drv = am | 4'(d);
                val = (am & addr_src) | (~am & dv);
                rb  = (drv & val) | (~drv & pin_in);
                check("R5/R6/R9 pin_oe", {4'h0, pin_oe}, {4'h0, drv});
                check("R5/R6/R9 pin_out", {4'h0, pin_out}, {4'h0, val & drv});
                check("R11 pin_pu", {4'h0, pin_pu}, {4'h0, ~drv});
                rd_check("R10 readback", A_PINS, {4'hF, rb});
            end
        end

        // R12 open-drain sweep, mode 0, all outputs
        mode = 3'd0;
        wr(A_DIR, 8'h0F);
        wr(A_PULL, 8'h00);
        for (int o = 0; o < 16; o++) begin
            for (int v = 0; v < 16; v++) begin
                wr(A_OPEN, 8'(o));
                wr(A_DATA, 8'(v));
                check("R12 pin_oe", {4'h0, pin_oe}, {4'h0, ~(4'(o) & 4'(v))});
                check("R12 pin_od", {4'h0, pin_od}, 8'(o));
                check("R12 pin_out", {4'h0, pin_out}, 8'(v));
            end
        end
        wr(A_OPEN, 8'h00);

        // R10 synchronizer latency and read-only readback
        wr(A_DIR, 8'h00);
        pin_in = 4'h5;
        @(negedge clk);
        rd_check("R10 one edge old", A_PINS, 8'hFA);
        @(negedge clk);
        rd_check("R10 two edges new", A_PINS, 8'hF5);
        wr(A_PINS, 8'h0F);
        rd_check("R10 write ignored", A_PINS, 8'hF5);

        // R7 hold in software standby
        mode = 3'd4; addr_src = 4'h5; stby_oe = 1'b1;
        @(negedge clk);
        sw_stby = 1'b1;
        @(negedge clk);
        addr_src = 4'hA;
        #0.5;
        check("R7 held address", {4'h0, pin_out}, 8'h05);
        check("R7 held oe", {4'h0, pin_oe}, 8'h0F);
        sw_stby = 1'b0;
        @(negedge clk);
        check("R5 live after exit", {4'h0, pin_out}, 8'h0A);

        // R8 high-impedance standby; R4 direction retained
        mode = 3'd0;
        wr(A_DIR, 8'h0F);
        wr(A_DATA, 8'h09);
        stby_oe = 1'b0;
        sw_stby = 1'b1;
        @(negedge clk);
        check("R8 gpio keeps driving", {4'h0, pin_oe}, 8'h0F);
        check("R8 gpio value", {4'h0, pin_out}, 8'h09);
        mode = 3'd4;
        #0.5 check("R8 address released", {4'h0, pin_oe}, 8'h00);
        mode = 3'd6;
        #0.5 check("R8 mode6 address released", {4'h0, pin_oe}, 8'h00);
        repeat (3) @(negedge clk);
        sw_stby = 1'b0;
        mode = 3'd0;
        @(negedge clk);
        check("R4 dir kept", {4'h0, pin_oe}, 8'h0F);

        // R3 hardware standby
        wr(A_PULL, 8'h0F);
        hw_stby = 1'b1;
        @(negedge clk);
        check("R3 hw oe", {4'h0, pin_oe}, 8'h00);
        check("R3 hw pu", {4'h0, pin_pu}, 8'h00);
        check("R3 hw od", {4'h0, pin_od}, 8'h00);
        wr(A_DATA, 8'h06);
        wr(A_DIR, 8'h0F);
        hw_stby = 1'b0;
        @(negedge clk);
        check("R3 dir cleared", {4'h0, pin_oe}, 8'h00);
        rd_check("R3 write ignored", A_DATA, 8'hF9);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule